// File: doc/BRIEF.md
# Chained Controller Serial Responder

This block stands in for a chain of up to eight game controllers on a console port that carries only a clock and a data line. The port has no select line. The console marks the start of a frame by holding its clock high for a long idle window. After that, every clock cycle reads one bit. The block counts that idle window in system clocks. When the window closes, it takes a snapshot of the per-slot report registers and then shifts the joined reports out, most significant bit first. The output bit changes on each falling edge of the console clock, so the console can sample it on the next rising edge, as in SPI mode 3.

Each slot carries a two-bit device code and a 72-bit report field, with byte 0 in the top bits. The device code sets how many bytes the slot adds to the stream. Slots go out in index order with no gaps between them. A slot marked empty adds nothing, and every later slot moves up to fill its place. Once the reports run out, the stream reads 0xFF. A frame-active output acts as a chip select built from the clock. It rises on the first falling clock edge of a frame and drops again when the next idle window closes.

Top module: `chain_pad_emu`

## Requirements
- R1: After reset, `sdo_out` is 1 and `frame_active` is 0. Clock edges arriving before the first full idle window leave both unchanged.
- R2: A frame starts only after the console clock has stayed high for IDLE_CYC = (CLK_HZ/1000)*IDLE_US/1000 system clocks in a row. Any low level resets that count, so a high pause shorter than the window continues the current frame.
- R3: The falling console edge number k (counting from 0) of a frame puts stream bit k on `sdo_out`. Bits go out MSB first within each byte. `sdo_out` does not change between falling edges.
- R4: Slot s uses device code `slot_type[2s+1:2s]`, where 0 = empty (0 bytes), 1 = pad (2 bytes), 2 = mouse (4 bytes) and 3 = flightstick (9 bytes). Report byte j of slot s is `slot_data[72s+71-8j -: 8]`. Slot 0 goes out first, and the slots follow one another with no gap and no padding.
- R5: In a pad report, the upper nibble of byte 0 always goes out as 4'b1000. Every other pad bit comes from the report field.
- R6: In a mouse report, byte 0 always goes out as 0x49, whatever the field holds. Bytes 1 to 3 come from the field.
- R7: Every byte after the last report byte reads 0xFF. Every byte at index MAX_BYTES (200) or later reads 0xFF.
- R8: The device codes and report fields are sampled once, when a frame starts. Changes to them during a frame only show up in the next frame.
- R9: The console data input `sdi_in` has no effect on `sdo_out` or `frame_active`.
- R10: `frame_active` is 0 when a frame starts. It goes to 1 on the first falling clock edge of that frame and stays 1 until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Console serial clock, asynchronous, idles high |
| sdi_in | input | 1 | Console serial data, ignored |
| slot_type | input | 2*NSLOT | Two-bit device code for each slot |
| slot_data | input | 72*NSLOT | Report field for each slot, byte 0 in the top bits |
| sdo_out | output | 1 | Serial report data to the console |
| frame_active | output | 1 | High from the first clock fall of a frame until the next frame start |

## Verification
The assertions check, on every cycle, the rules that tie the edge detector and the shifter together:
- the output holds between falling edges;
- a frame start returns the line to its quiet state;
- the active strobe rises only on a falling edge;
- the byte index moves by at most one per cycle.

Whether the right bytes appear in the right order can only be shown by the bench's frames, each compared against a model. Those frames cover empty-slot compaction, the pad marker nibble, the forced mouse ID, 0xFF fill past the reports and past the byte limit, a short clock pause, and register changes in the middle of a frame.

// File: rtl/chain_pad_pkg.sv
package chain_pad_pkg;
  typedef enum logic [1:0] {
    DEV_NONE  = 2'd0,
    DEV_PAD   = 2'd1,
    DEV_MOUSE = 2'd2,
    DEV_STICK = 2'd3
  } dev_e;

  localparam int REP_BYTES = 9;
  localparam int REP_W     = REP_BYTES * 8;
  localparam logic [7:0] MOUSE_ID  = 8'h49;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [3:0] PAD_MARK  = 4'h8;

  function automatic logic [3:0] dev_len(input logic [1:0] t);
    case (t)
      2'd1:    dev_len = 4'd2;
      2'd2:    dev_len = 4'd4;
      2'd3:    dev_len = 4'd9;
      default: dev_len = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/clk_edge_watch.sv
module clk_edge_watch #(
  parameter int IDLE_CYC = 24000
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  output logic fall_p,
  output logic start_p
);
  localparam int CNT_W = $clog2(IDLE_CYC + 1);

  logic s1, s2, prev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= sclk_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign fall_p = prev & ~s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      start_p <= 1'b0;
    end else begin
      start_p <= s2 && (cnt == CNT_W'(IDLE_CYC - 1));
      if (!s2)
        cnt <= '0;
      else if (cnt != CNT_W'(IDLE_CYC))
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/report_bank.sv
module report_bank import chain_pad_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int BW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [2*NSLOT-1:0]     slot_type,
  input  logic [REP_W*NSLOT-1:0] slot_data,
  input  logic [BW-1:0]          byte_idx,
  output logic [7:0]             byte_o
);
  localparam int OFF_W = $clog2(NSLOT * REP_BYTES + 1);

  logic [OFF_W-1:0] off_d [NSLOT];
  logic [NSLOT-1:0] hit;
  logic [7:0]       sel [NSLOT];

  always_comb begin : prefix
    logic [OFF_W-1:0] acc;
    acc = '0;
    for (int s = 0; s < NSLOT; s++) begin
      off_d[s] = acc;
      acc = acc + OFF_W'(dev_len(slot_type[2*s +: 2]));
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [REP_W-1:0] fmt, data_q, shifted;
    logic [1:0]       typ_q;
    logic [OFF_W-1:0] off_q;
    logic [3:0]       ri;
    int               rel;

    always_comb begin
      fmt = slot_data[REP_W*g +: REP_W];
      case (dev_e'(slot_type[2*g +: 2]))
        DEV_PAD:   fmt[REP_W-1 -: 4] = PAD_MARK;
        DEV_MOUSE: fmt[REP_W-1 -: 8] = MOUSE_ID;
        default:   ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q <= '0;
        typ_q  <= DEV_NONE;
        off_q  <= '0;
      end else if (load) begin
        data_q <= fmt;
        typ_q  <= slot_type[2*g +: 2];
        off_q  <= off_d[g];
      end
    end

    always_comb begin
      rel    = int'(byte_idx) - int'(off_q);
      hit[g] = (typ_q != DEV_NONE) && (rel >= 0) && (rel < int'(dev_len(typ_q)));
      ri     = hit[g] ? rel[3:0] : 4'd0;
      shifted = data_q << {ri, 3'b000};
      sel[g] = shifted[REP_W-1 -: 8];
    end
  end

  always_comb begin
    byte_o = FILL_BYTE;
    for (int s = 0; s < NSLOT; s++)
      if (hit[s]) byte_o = sel[s];
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int MAXB = 200,
  parameter int BW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fall,
  input  logic [7:0]    byte_in,
  output logic [BW-1:0] byte_idx,
  output logic          sdo,
  output logic          frame_act
);
  logic [2:0] bit_q;
  logic       armed;
  logic       past_end;

  assign past_end = int'(byte_idx) >= MAXB;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      byte_idx  <= '0;
      bit_q     <= '0;
      sdo       <= 1'b1;
      frame_act <= 1'b0;
    end else if (start) begin
      armed     <= 1'b1;
      byte_idx  <= '0;
      bit_q     <= '0;
      sdo       <= 1'b1;
      frame_act <= 1'b0;
    end else if (fall && armed) begin
      sdo       <= past_end ? 1'b1 : byte_in[3'd7 - bit_q];
      frame_act <= 1'b1;
      bit_q     <= bit_q + 1'b1;
      if (bit_q == 3'd7 && !past_end)
        byte_idx <= byte_idx + 1'b1;
    end
  end
endmodule

// File: rtl/chain_pad_emu.sv
module chain_pad_emu import chain_pad_pkg::*; #(
  parameter int NSLOT     = 8,
  parameter int CLK_HZ    = 48_000_000,
  parameter int IDLE_US   = 500,
  parameter int MAX_BYTES = 200
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk_in,
  input  logic                   sdi_in,
  input  logic [2*NSLOT-1:0]     slot_type,
  input  logic [REP_W*NSLOT-1:0] slot_data,
  output logic                   sdo_out,
  output logic                   frame_active
);
  localparam int IDLE_CYC = (CLK_HZ / 1000) * IDLE_US / 1000;
  localparam int BW       = $clog2(MAX_BYTES + 1);

  logic          fall_p, start_p;
  logic [BW-1:0] byte_idx;
  logic [7:0]    cur_byte;
  logic          unused_sdi;

  assign unused_sdi = sdi_in;

  clk_edge_watch #(.IDLE_CYC(IDLE_CYC)) u_watch (
    .clk(clk), .rst(rst), .sclk_in(sclk_in),
    .fall_p(fall_p), .start_p(start_p)
  );

  report_bank #(.NSLOT(NSLOT), .BW(BW)) u_bank (
    .clk(clk), .rst(rst), .load(start_p),
    .slot_type(slot_type), .slot_data(slot_data),
    .byte_idx(byte_idx), .byte_o(cur_byte)
  );

  frame_shifter #(.MAXB(MAX_BYTES), .BW(BW)) u_shift (
    .clk(clk), .rst(rst), .start(start_p), .fall(fall_p),
    .byte_in(cur_byte), .byte_idx(byte_idx),
    .sdo(sdo_out), .frame_act(frame_active)
  );
endmodule

// File: rtl/chain_pad_chk.sv
module chain_pad_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          fall,
  input logic [BW-1:0] byte_idx,
  input logic          sdo,
  input logic          frame_act
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> (sdo && !frame_act));

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall && !start) |=> $stable(sdo));

  // R10
  start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (sdo && !frame_act && byte_idx == '0));

  // R10
  act_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_act) |-> $past(fall));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (byte_idx == $past(byte_idx) || byte_idx == BW'($past(byte_idx) + 1'b1)));
endmodule

bind chain_pad_emu chain_pad_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .start(start_p), .fall(fall_p),
  .byte_idx(byte_idx), .sdo(sdo_out), .frame_act(frame_active)
);

// File: tb/tb_chain_pad_emu.sv
module tb_chain_pad_emu;
  localparam int NSLOT = 8;
  localparam int IDLE  = 500;
  localparam int HALF  = 6;
  localparam int MAXB  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [2*NSLOT-1:0]  ty = '0;
  logic [72*NSLOT-1:0] dat = '0;
  logic sdo, fact;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  chain_pad_emu #(.NSLOT(NSLOT), .CLK_HZ(1_000_000), .IDLE_US(IDLE), .MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdi_in(sdi),
    .slot_type(ty), .slot_data(dat), .sdo_out(sdo), .frame_active(fact)
  );

  // slot types packed 16 bits, bytes to read 16 bits
  localparam logic [31:0] VEC [4] = '{
    {16'h5555, 16'd20},
    {16'h00D2, 16'd18},
    {16'h0000, 16'd4},
    {16'h8000, 16'd6}
  };

  function automatic logic [7:0] gen(input int s, input int j, input int seed);
    return 8'(8'h21 + 16 * s + j + seed);
  endfunction

  function automatic int tlen(input logic [1:0] t);
    case (t) 2'd1: return 2; 2'd2: return 4; 2'd3: return 9; default: return 0; endcase
  endfunction

  function automatic logic [7:0] model(input logic [15:0] tw, input int seed, input int k);
    int acc = 0;
    logic [7:0] b;
    if (k >= MAXB) return 8'hFF;
    for (int s = 0; s < NSLOT; s++) begin
      int l = tlen(tw[2*s +: 2]);
      if (k >= acc && k < acc + l) begin
        b = gen(s, k - acc, seed);
        if (k == acc && tw[2*s +: 2] == 2'd2) b = 8'h49;
        if (k == acc && tw[2*s +: 2] == 2'd1) b = {4'h8, b[3:0]};
        return b;
      end
      acc += l;
    end
    return 8'hFF;
  endfunction

  task automatic load_regs(input logic [15:0] tw, input int seed);
    ty = tw;
    for (int s = 0; s < NSLOT; s++)
      for (int j = 0; j < 9; j++)
        dat[72*s + 71 - 8*j -: 8] = gen(s, j, seed);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_high(input int n);
    @(negedge clk) sclk = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b, output bit moved);
    moved = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sdi = ~sdi;
      repeat (HALF) @(negedge clk);
      b[7-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdo != b[7-i]) moved = 1'b1;
    end
  endtask

  task automatic run_frame(input logic [15:0] tw, input int seed, input int n, input string tag);
    logic [7:0] b;
    bit mv;
    idle_high(IDLE + 20);
    for (int k = 0; k < n; k++) begin
      read_byte(b, mv);
      chk(b == model(tw, seed, k), tag, b, model(tw, seed, k));
      chk(!mv, "R3 sdo moved in high phase", mv, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit mv;
    load_regs(16'h5555, 0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo == 1'b1, "R1 reset sdo", sdo, 1);
    chk(fact == 1'b0, "R1 reset frame_active", fact, 0);
    for (int i = 0; i < 16; i++) begin
      sclk = ~sclk;
      repeat (HALF) @(negedge clk);
    end
    chk(sdo == 1'b1 && fact == 1'b0, "R1 edges before idle window", {sdo, fact}, 2);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      load_regs(VEC[v][31:16], v);
      run_frame(VEC[v][31:16], v, int'(VEC[v][15:0]), "R4 stream byte");
    end

    // R10 / R9: strobe at start and after first edge, sdi toggles in idle
    load_regs(16'h0006, 3);
    idle_high(IDLE + 20);
    chk(fact == 1'b0, "R10 active low at start", fact, 0);
    for (int i = 0; i < 20; i++) begin
      sdi = ~sdi;
      @(negedge clk);
    end
    chk(sdo == 1'b1 && fact == 1'b0, "R9 sdi ignored", {sdo, fact}, 2);
    read_byte(b, mv);
    chk(fact == 1'b1, "R10 active after first edge", fact, 1);
    chk(b == 8'h49, "R6 mouse id in slot0", b, 8'h49);

    // R2: short high pause keeps the frame running
    read_byte(b, mv);
    repeat (300) @(negedge clk);
    read_byte(b, mv);
    chk(b == model(16'h0006, 3, 2), "R2 short pause continues", b, model(16'h0006, 3, 2));
    chk(fact == 1'b1, "R10 active held", fact, 1);

    // R8: mid-frame change only lands in next frame
    load_regs(16'h0001, 9);
    read_byte(b, mv);
    chk(b == model(16'h0006, 3, 3), "R8 old snapshot kept", b, model(16'h0006, 3, 3));
    read_byte(b, mv);
    chk(b == model(16'h0006, 3, 4), "R8 old snapshot kept", b, model(16'h0006, 3, 4));
    run_frame(16'h0001, 9, 3, "R8 new snapshot next frame");

    // R7: past the byte limit everything is fill
    load_regs(16'hFFFF, 5);
    run_frame(16'hFFFF, 5, MAXB + 3, "R7 long frame");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule